// File: doc/BRIEF.md
# DMA Interrupt Status Aggregator

This unit gathers completion events from every channel of a multi-channel DMA engine and turns them into one shared interrupt line. Each channel sends a one-cycle done pulse. The pulse sets that channel's bit in a status register. A per-channel enable register masks the status, and a read-only pending view shows status AND enable. While any pending bit is set, the interrupt line is raised. Software clears events one bit at a time by writing ones to the status register.

All access goes through a plain 32-bit register bus: address, write enable, write data, and read data. Read data is combinational from the addressed register. A small control register holds an address-width mode bit, which is driven out to the rest of the engine.

The interrupt line is set by a two-state machine. In `LINE_QUIET` the line is low. In `LINE_RAISED` the line is high. Two transitions move between them:
- `QUIET→RAISED` is taken when the pending bits are non-zero.
- `RAISED→QUIET` is taken when the pending bits are all zero.

Top module: `dma_irq_aggregator`

## Requirements
- R1: A done pulse on `chan_done[i]` in one cycle sets bit i of the status register, at address 0x080000, from the next cycle on. This happens whether or not bit i is enabled. No status bit is set without a done pulse.
- R2: A write to the status address clears each status bit whose write-data bit is 1. Bits written as 0 are unchanged. Writing 0xFFFFFFFF clears every channel.
- R3: If a done pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R4: Reading address 0x080004 returns status AND enable. Writes to that address change nothing.
- R5: The enable register at address 0x080008 is read/write in bits NUM_CH-1:0. Writing 0 to it lowers the interrupt line, and latched status bits are kept.
- R6: `irq_out` is 1 exactly in the cycle after one in which status AND enable was non-zero. It is 0 otherwise.
- R7: In the control register at address 0x34, bit 0 is the 32-bit address mode. It is driven on `wide_addr_mode` and reads back in bit 0. All other bits read 0.
- R8: Status, pending and enable bits at positions NUM_CH and above read 0. Unmapped addresses read 0.
- R9: After reset, status, enable and control are all 0, and `irq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_done | input | NUM_CH | Per-channel one-cycle completion pulses |
| bus_addr | input | ADDR_W | Register bus byte address |
| bus_we | input | 1 | Register bus write strobe |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Register bus read data (combinational) |
| wide_addr_mode | output | 1 | Control bit 0: 32-bit address mode |
| irq_out | output | 1 | Shared interrupt line |

## Verification
The bench fires done pulses while the channel is disabled. A design that gated status latching with enable would then read a zero status. The bench also lands a clearing write and a fresh done pulse on the same bit in the same cycle. A design that let the clear win would lose a completion event. Other cases are:
- Writes to the pending address: a design that decoded pending as writable would corrupt status or enable.
- Writes of all ones: a design that did not hide unused upper bits would read back bits above the channel count.
- Toggling enable to zero while status is latched: a design that cleared status on disable would drop events.
- The exact cycle the line rises and falls: a design that drove the line combinationally, or two cycles late, would be caught there.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_PEND,
        SEL_ENABLE,
        SEL_CTRL
    } reg_sel_e;

    localparam int unsigned BUS_W = 32;

endpackage

// File: rtl/irqagg_regdec.sv
module irqagg_regdec
    import irqagg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned STATUS_OFS = 'h80000,
    parameter int unsigned PEND_OFS   = 'h80004,
    parameter int unsigned ENABLE_OFS = 'h80008,
    parameter int unsigned CTRL_OFS   = 'h34
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output reg_sel_e          sel,
    output logic              wr_status,
    output logic              wr_enable,
    output logic              wr_ctrl
);

    always_comb begin
        sel = SEL_NONE;
        if (addr == ADDR_W'(STATUS_OFS))      sel = SEL_STATUS;
        else if (addr == ADDR_W'(PEND_OFS))   sel = SEL_PEND;
        else if (addr == ADDR_W'(ENABLE_OFS)) sel = SEL_ENABLE;
        else if (addr == ADDR_W'(CTRL_OFS))   sel = SEL_CTRL;
    end

    // Pending is a read-only view: no write strobe is produced for it.
    assign wr_status = we && (sel == SEL_STATUS);
    assign wr_enable = we && (sel == SEL_ENABLE);
    assign wr_ctrl   = we && (sel == SEL_CTRL);

endmodule

// File: rtl/irqagg_bank.sv
module irqagg_bank #(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] done,
    input  logic [NUM_CH-1:0] wdata,
    input  logic              wr_status,
    input  logic              wr_enable,
    output logic [NUM_CH-1:0] status,
    output logic [NUM_CH-1:0] enable
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        logic clr_hit;
        assign clr_hit = wr_status && wdata[ch];

        // A fresh event outranks a clearing write in the same cycle.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          status[ch] <= 1'b0;
            else if (done[ch])   status[ch] <= 1'b1;
            else if (clr_hit)    status[ch] <= 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          enable[ch] <= 1'b0;
            else if (wr_enable)  enable[ch] <= wdata[ch];
        end
    end

endmodule

// File: rtl/irqagg_line_fsm.sv
module irqagg_line_fsm
    import irqagg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_pend,
    output logic irq
);

    line_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET:  if (any_pend)  state_d = LINE_RAISED;
            LINE_RAISED: if (!any_pend) state_d = LINE_QUIET;
            default:                    state_d = LINE_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = 1'b0;
        unique case (state_q)
            LINE_QUIET:  irq = 1'b0;
            LINE_RAISED: irq = 1'b1;
            default:     irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_CH     = 8,
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned STATUS_OFS = 'h80000,
    parameter int unsigned PEND_OFS   = 'h80004,
    parameter int unsigned ENABLE_OFS = 'h80008,
    parameter int unsigned CTRL_OFS   = 'h34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_done,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wide_addr_mode,
    output logic              irq_out
);

    reg_sel_e          sel;
    logic              wr_status, wr_enable, wr_ctrl;
    logic [NUM_CH-1:0] status_q, enable_q, pend;
    logic              ctrl_q;
    logic              unused_wdata_bits;

    assign unused_wdata_bits = ^bus_wdata;

    irqagg_regdec #(
        .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS), .PEND_OFS(PEND_OFS),
        .ENABLE_OFS(ENABLE_OFS), .CTRL_OFS(CTRL_OFS)
    ) u_dec (
        .addr(bus_addr), .we(bus_we), .sel(sel),
        .wr_status(wr_status), .wr_enable(wr_enable), .wr_ctrl(wr_ctrl)
    );

    irqagg_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk(clk), .rst_n(rst_n), .done(chan_done),
        .wdata(bus_wdata[NUM_CH-1:0]),
        .wr_status(wr_status), .wr_enable(wr_enable),
        .status(status_q), .enable(enable_q)
    );

    assign pend = status_q & enable_q;

    irqagg_line_fsm u_line (
        .clk(clk), .rst_n(rst_n), .any_pend(|pend), .irq(irq_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= 1'b0;
        else if (wr_ctrl) ctrl_q <= bus_wdata[0];
    end
    assign wide_addr_mode = ctrl_q;

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_STATUS: bus_rdata[NUM_CH-1:0] = status_q;
            SEL_PEND:   bus_rdata[NUM_CH-1:0] = pend;
            SEL_ENABLE: bus_rdata[NUM_CH-1:0] = enable_q;
            SEL_CTRL:   bus_rdata[0]          = ctrl_q;
            default:    bus_rdata             = '0;
        endcase
    end

endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
    parameter int unsigned NUM_CH     = 8,
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned STATUS_OFS = 'h80000,
    parameter int unsigned PEND_OFS   = 'h80004,
    parameter int unsigned ENABLE_OFS = 'h80008
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] chan_done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              irq_out,
    input logic [NUM_CH-1:0] status_q,
    input logic [NUM_CH-1:0] enable_q
);

    // R1 R3
    done_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_done) |=> ((status_q & $past(chan_done)) == $past(chan_done)));

    // R1
    no_phantom_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(chan_done)) == '0));

    // R2
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(STATUS_OFS) &&
         (chan_done & bus_wdata[NUM_CH-1:0]) == '0)
        |=> ((status_q & $past(bus_wdata[NUM_CH-1:0])) == '0));

    // R4
    pend_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(PEND_OFS)) |-> (bus_rdata[NUM_CH-1:0] == (status_q & enable_q)));

    // R5
    enable_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(ENABLE_OFS) && chan_done == '0)
        |=> (status_q == $past(status_q)));

    // R6
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(|(status_q & enable_q))));

endmodule

bind dma_irq_aggregator irqagg_chk #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS),
    .PEND_OFS(PEND_OFS), .ENABLE_OFS(ENABLE_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .chan_done(chan_done), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .status_q(status_q), .enable_q(enable_q)
);

// File: tb/test_dma_irq_aggregator.sv
module test_dma_irq_aggregator;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 8;
    localparam int AW         = 20;
    localparam logic [AW-1:0] A_STAT = 20'h80000;
    localparam logic [AW-1:0] A_PEND = 20'h80004;
    localparam logic [AW-1:0] A_EN   = 20'h80008;
    localparam logic [AW-1:0] A_CTRL = 20'h00034;
    localparam logic [AW-1:0] A_NONE = 20'h80010;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  chan_done = '0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            wide_addr_mode;
    logic            irq_out;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // behavioural reference state
    int unsigned m_stat = 0, m_en = 0, m_ctrl = 0;
    bit          m_irq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_aggregator #(.NUM_CH(NCH), .ADDR_W(AW)) i_dma_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .chan_done(chan_done), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wide_addr_mode(wide_addr_mode), .irq_out(irq_out)
    );

    function automatic int unsigned model_read(logic [AW-1:0] a);
        if (a == A_STAT) return m_stat;
        if (a == A_PEND) return m_stat & m_en;
        if (a == A_EN)   return m_en;
        if (a == A_CTRL) return m_ctrl;
        return 0;
    endfunction

    function automatic string tag_of(logic [AW-1:0] a);
        if (a == A_STAT) return "R1/R2/R3 status";
        if (a == A_PEND) return "R4 pending";
        if (a == A_EN)   return "R5 enable";
        if (a == A_CTRL) return "R7 control";
        return "R8 unmapped";
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // One bus cycle; compares outputs against the model, then advances it.
    task automatic step(logic [AW-1:0] a, logic we, logic [31:0] wd,
                        logic [NCH-1:0] dn, string tag = "");
        string t;
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = wd; chan_done = dn;
        #1;
        t = (tag == "") ? tag_of(a) : tag;
        check(t, bus_rdata, model_read(a));
        check((tag == "") ? "R6 irq_out" : tag, {31'b0, irq_out}, {31'b0, m_irq});
        check((tag == "") ? "R7 wide_addr_mode" : tag, {31'b0, wide_addr_mode}, m_ctrl);
        @(posedge clk);
        m_irq = ((m_stat & m_en) != 0);
        if (we && a == A_STAT) m_stat = m_stat & ~(wd & 32'hFF);
        if (we && a == A_EN)   m_en   = wd & 32'hFF;
        if (we && a == A_CTRL) m_ctrl = wd & 1;
        m_stat = m_stat | 32'(dn);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R9 reset state
        step(A_STAT, 0, 0, 0, "R9 reset");
        step(A_EN,   0, 0, 0, "R9 reset");
        step(A_CTRL, 0, 0, 0, "R9 reset");
        // R1 latch while disabled, irq stays low (R6)
        step(A_STAT, 0, 0, 8'h81);
        step(A_STAT, 0, 0, 8'h04);
        step(A_STAT, 0, 0, 0);
        step(A_PEND, 0, 0, 0);
        // R5 enable, R4 pending, R6 rise
        step(A_EN, 1, 32'h05, 0);
        step(A_PEND, 0, 0, 0);
        step(A_PEND, 0, 0, 0);
        // R2 clear one bit, zeros untouched
        step(A_STAT, 1, 32'h01, 0);
        step(A_STAT, 1, 32'h00, 0);
        step(A_STAT, 0, 0, 0);
        // R3 clear and event on same bit
        step(A_STAT, 1, 32'h04, 8'h04);
        step(A_STAT, 0, 0, 0);
        // R5 disable keeps status, irq falls
        step(A_EN, 1, 0, 0);
        step(A_STAT, 0, 0, 0);
        step(A_STAT, 0, 0, 0);
        // R4 writes to pending ignored
        step(A_PEND, 1, 32'hFFFFFFFF, 0);
        step(A_EN, 0, 0, 0);
        step(A_STAT, 0, 0, 0);
        // R8 upper bits and unmapped
        step(A_EN, 1, 32'hFFFFFFFF, 0);
        step(A_EN, 0, 0, 0);
        step(A_NONE, 1, 32'hFFFFFFFF, 0);
        step(A_NONE, 0, 0, 0);
        // R2 all ones clears every channel
        step(A_STAT, 1, 32'hFFFFFFFF, 0);
        step(A_STAT, 0, 0, 0);
        // R7 control bit
        step(A_CTRL, 1, 32'hFFFFFFFF, 0);
        step(A_CTRL, 0, 0, 0);
        step(A_CTRL, 1, 32'h2, 0);
        step(A_CTRL, 0, 0, 0);
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            int unsigned r = $urandom % 6;
            logic [AW-1:0] a;
            a = (r == 0) ? A_STAT : (r == 1) ? A_PEND : (r == 2) ? A_EN :
                (r == 3) ? A_CTRL : (r == 4) ? A_STAT : A_NONE;
            step(a, ($urandom % 3) == 0, $urandom, NCH'($urandom & $urandom));
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule